// File: doc/BRIEF.md
# Interrupt Source P/Q Gate

This block keeps a two-bit event state for each of a set of interrupt sources and decides, event by event, whether a source may send a notification downstream. The two bits are P (an event has been presented and not yet acknowledged) and Q (another event arrived while P was set). Devices raise one-cycle trigger pulses, and software reaches each source through a memory-mapped page. Loads in that page read the state and can overwrite it. Stores in that page perform an acknowledge, or act as a trigger.

No separate mask bit exists. Masking is done through the state encodings. State `10` holds new events in Q so they can be replayed later. State `01` is a hard off state in which events are dropped. A store-EOI moves Q into P and sends again if an event was held. Sources can be message-signalled or level-sensitive, and a level-sensitive source never holds Q. Three things are per-source parameters: the source kind, support for store-EOI, and whether the source has a separate trigger page. The page size and an offset quirk that moves the operation field up by four bits are block parameters.

Top module: `pq_source_gate`

## Requirements
- R1: After reset, every message-signalled source is in state `01`, every level-sensitive source is in state `10`, `ntf_vec` is all zero and `rd_valid` is low.
- R2: A trigger on a message-signalled source behaves as follows:
  - in `00` it notifies and moves to `10`;
  - in `10` it moves to `11` without notifying;
  - in `11` it stays `11` without notifying.
- R3: A trigger on a message-signalled source in state `01` is dropped. The state stays `01` and no notification is sent.
- R4: A level-sensitive source behaves as follows:
  - a trigger with P=0 notifies and sets P;
  - a trigger with P=1 has no effect;
  - Q is always 0, including after a load that writes a Q of 1.
- R5: A load whose operation nibble is `0xC`, `0xD`, `0xE` or `0xF` returns the old state on `rd_pq` (bit 1 = P, bit 0 = Q) with `rd_valid` one cycle later. It then sets the state to nibble bits [1:0], so the nibbles give `00`, `01`, `10` and `11` in turn.
- R6: A load at any other nibble returns the state and leaves it unchanged.
- R7: A store at nibble `0x0` to a store-EOI source copies Q into P and clears Q. It notifies if the new P is 1.
- R8: A store at nibble `0x0` to a source that has neither store-EOI nor a separate trigger page acts exactly as a trigger.
- R9: The following stores change nothing and send no notification:
  - a store at nibble `0x0` to a source with a separate trigger page and no store-EOI;
  - a store at any nonzero nibble.
- R10: The source index is `op_addr[ADDR_W-1:PAGE_SHIFT]`. The operation nibble is `op_addr[11:8]`, or `op_addr[15:12]` when the offset quirk is set. All other page-offset bits are ignored.
- R11: When an operation and a trigger hit the same source in the same cycle, the operation is applied first and the trigger is applied to its result.
- R12: A notification appears as a one-cycle pulse on the source's bit of `ntf_vec`, in the cycle after the one that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Trigger pulse from a device |
| trig_src | input | SRC_W | Source index of the trigger |
| op_valid | input | 1 | Memory-mapped operation present |
| op_write | input | 1 | 1 = store, 0 = load |
| op_addr | input | ADDR_W | Source index and offset within its page |
| rd_valid | output | 1 | Load result valid |
| rd_pq | output | 2 | Old state for a load, {P,Q} |
| ntf_vec | output | NUM_SRC | Per-source notification pulses |

## Verification
Both results of a stimulus are registered once. The `ntf_vec` pulse and any load result appear in the cycle after the edge that sampled the inputs. The bench drives inputs on a falling edge and updates its own model of every source's state. It then compares `ntf_vec`, `rd_valid` and `rd_pq` on the next falling edge, exactly one register stage later. The bench cannot see the stored state directly, so it checks state changes through later loads and later notification pulses.

// File: rtl/pq_gate_pkg.sv
package pq_gate_pkg;

    typedef struct packed {
        logic p;
        logic q;
    } pq_t;

    typedef enum logic [1:0] {
        PQ_OP_NONE  = 2'd0,
        PQ_OP_READ  = 2'd1,
        PQ_OP_SET   = 2'd2,
        PQ_OP_STORE = 2'd3
    } pq_op_e;

    typedef struct packed {
        pq_t  st;
        logic fwd;
    } pq_res_t;

    localparam logic [3:0] NIB_STORE = 4'h0;

    // Trigger rule: notify from an idle state, otherwise record in Q (MSI only).
    function automatic pq_res_t pq_fire(pq_t s, logic lsi);
        pq_res_t r;
        r.st  = s;
        r.fwd = 1'b0;
        if (!s.p) begin
            if (lsi || !s.q) begin
                r.st.p = 1'b1;
                r.fwd  = 1'b1;
            end
        end else if (!lsi) begin
            r.st.q = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pq_op_decode.sv
module pq_op_decode
    import pq_gate_pkg::*;
#(
    parameter int SRC_W        = 3,
    parameter int PAGE_SHIFT   = 12,
    parameter bit OFFSET_QUIRK = 1'b0,
    localparam int ADDR_W      = SRC_W + PAGE_SHIFT
) (
    input  logic              op_valid,
    input  logic              op_write,
    input  logic [ADDR_W-1:0] op_addr,
    output logic [SRC_W-1:0]  dec_src,
    output pq_op_e            dec_kind,
    output logic [1:0]        dec_setval
);
    localparam int NIB_LSB = OFFSET_QUIRK ? 12 : 8;
    localparam logic [PAGE_SHIFT-1:0] NIB_MASK =
        {{(PAGE_SHIFT-4){1'b0}}, 4'hF} << NIB_LSB;

    logic [3:0] nib;
    logic       addr_unused;

    assign dec_src     = op_addr[ADDR_W-1:PAGE_SHIFT];
    assign nib         = op_addr[NIB_LSB+3:NIB_LSB];
    assign dec_setval  = nib[1:0];
    assign addr_unused = ^(op_addr[PAGE_SHIFT-1:0] & ~NIB_MASK);

    always_comb begin
        dec_kind = PQ_OP_NONE;
        if (op_valid) begin
            if (op_write)
                dec_kind = (nib == NIB_STORE) ? PQ_OP_STORE : PQ_OP_NONE;
            else
                dec_kind = (nib[3:2] == 2'b11) ? PQ_OP_SET : PQ_OP_READ;
        end
    end
endmodule

// File: rtl/pq_src_cell.sv
module pq_src_cell
    import pq_gate_pkg::*;
#(
    parameter bit IS_LSI        = 1'b0,
    parameter bit HAS_SEOI      = 1'b0,
    parameter bit HAS_TRIG_PAGE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       op_hit,
    input  pq_op_e     op_kind,
    input  logic [1:0] op_setval,
    input  logic       trig_hit,
    output pq_t        pq_q,
    output logic       fwd_q
);
    localparam pq_t RST_PQ = IS_LSI ? 2'b10 : 2'b01;

    pq_t     pq_d;
    logic    fwd_d;
    pq_res_t res_op;
    pq_res_t res_tr;

    always_comb begin
        pq_d   = pq_q;
        fwd_d  = 1'b0;
        res_op = pq_fire(pq_q, IS_LSI);
        if (op_hit) begin
            case (op_kind)
                PQ_OP_SET: begin
                    pq_d.p = op_setval[1];
                    pq_d.q = IS_LSI ? 1'b0 : op_setval[0];
                end
                PQ_OP_STORE: begin
                    if (HAS_SEOI) begin
                        pq_d.p = pq_q.q;
                        pq_d.q = 1'b0;
                        fwd_d  = pq_q.q;
                    end else if (!HAS_TRIG_PAGE) begin
                        pq_d  = res_op.st;
                        fwd_d = res_op.fwd;
                    end
                end
                default: ;
            endcase
        end
        res_tr = pq_fire(pq_d, IS_LSI);
        if (trig_hit) begin
            pq_d  = res_tr.st;
            fwd_d = fwd_d | res_tr.fwd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pq_q  <= RST_PQ;
            fwd_q <= 1'b0;
        end else begin
            pq_q  <= pq_d;
            fwd_q <= fwd_d;
        end
    end

    // R3: off state is left only by a software operation, never notifies
    assert_off_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (pq_q == 2'b01 && !op_hit) |=> (pq_q == 2'b01 && !fwd_q));

    // R2: a presented source never notifies again from a trigger alone
    assert_pending_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (pq_q.p && !op_hit) |=> !fwd_q);

    // R12: every notification leaves the source presented
    assert_fwd_sets_p_R12: assert property (@(posedge clk) disable iff (rst)
        fwd_q |-> pq_q.p);

    generate
        if (IS_LSI) begin : g_lsi_chk
            // R4: a level-sensitive source never holds Q
            assert_lsi_no_q_R4: assert property (@(posedge clk) disable iff (rst)
                !pq_q.q);
        end
    endgenerate
endmodule

// File: rtl/pq_source_gate.sv
module pq_source_gate
    import pq_gate_pkg::*;
#(
    parameter int                NUM_SRC        = 8,
    parameter int                PAGE_SHIFT     = 12,
    parameter bit                OFFSET_QUIRK   = 1'b0,
    parameter logic [NUM_SRC-1:0] LSI_MASK       = 8'b1100_0000,
    parameter logic [NUM_SRC-1:0] SEOI_MASK      = 8'b0000_0111,
    parameter logic [NUM_SRC-1:0] TRIG_PAGE_MASK = 8'b0011_0000,
    localparam int               SRC_W          = $clog2(NUM_SRC),
    localparam int               ADDR_W         = SRC_W + PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_valid,
    input  logic [SRC_W-1:0]   trig_src,
    input  logic               op_valid,
    input  logic               op_write,
    input  logic [ADDR_W-1:0]  op_addr,
    output logic               rd_valid,
    output logic [1:0]         rd_pq,
    output logic [NUM_SRC-1:0] ntf_vec
);
    logic [SRC_W-1:0] dec_src;
    pq_op_e           dec_kind;
    logic [1:0]       dec_setval;
    pq_t              pq_all [NUM_SRC];
    logic [1:0]       rd_next;

    pq_op_decode #(
        .SRC_W(SRC_W), .PAGE_SHIFT(PAGE_SHIFT), .OFFSET_QUIRK(OFFSET_QUIRK)
    ) u_dec (
        .op_valid(op_valid), .op_write(op_write), .op_addr(op_addr),
        .dec_src(dec_src), .dec_kind(dec_kind), .dec_setval(dec_setval)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            pq_src_cell #(
                .IS_LSI(LSI_MASK[i]),
                .HAS_SEOI(SEOI_MASK[i]),
                .HAS_TRIG_PAGE(TRIG_PAGE_MASK[i])
            ) u_cell (
                .clk(clk), .rst(rst),
                .op_hit(dec_kind != PQ_OP_NONE && dec_src == SRC_W'(i)),
                .op_kind(dec_kind), .op_setval(dec_setval),
                .trig_hit(trig_valid && trig_src == SRC_W'(i)),
                .pq_q(pq_all[i]), .fwd_q(ntf_vec[i])
            );
        end
    endgenerate

    always_comb begin
        rd_next = 2'b00;
        for (int i = 0; i < NUM_SRC; i++)
            if (dec_src == SRC_W'(i)) rd_next = pq_all[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_pq    <= 2'b00;
        end else begin
            rd_valid <= op_valid && !op_write;
            rd_pq    <= (op_valid && !op_write) ? rd_next : 2'b00;
        end
    end

    // R5: every load is answered exactly one cycle later
    assert_load_answer_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_write) |=> rd_valid);

    // R9: no answer appears without a load
    assert_no_spurious_rd_R9: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && !op_write) |=> !rd_valid);
endmodule

// File: tb/sim_pq_source_gate.sv
module sim_pq_source_gate;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] LSI  = 8'b1100_0000;
    localparam logic [7:0] SEOI = 8'b0000_0111;
    localparam logic [7:0] TPG  = 8'b0011_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_valid = 1'b0;
    logic [2:0]  trig_src = '0;
    logic        op_valid = 1'b0;
    logic        op_write = 1'b0;
    logic [14:0] op_addr = '0;
    logic        rd_valid;
    logic [1:0]  rd_pq;
    logic [7:0]  ntf_vec;

    logic        q_op_valid = 1'b0;
    logic [18:0] q_op_addr = '0;
    logic        q_rd_valid;
    logic [1:0]  q_rd_pq;
    logic [7:0]  q_ntf_vec;

    int n_cmp = 0;
    int n_bad = 0;

    logic [1:0] m_pq [8];
    logic [7:0] exp_ntf;
    logic       exp_rv;
    logic [1:0] exp_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    pq_source_gate #(.NUM_SRC(8), .PAGE_SHIFT(12), .OFFSET_QUIRK(1'b0),
        .LSI_MASK(LSI), .SEOI_MASK(SEOI), .TRIG_PAGE_MASK(TPG)) u0 (
        .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_src(trig_src),
        .op_valid(op_valid), .op_write(op_write), .op_addr(op_addr),
        .rd_valid(rd_valid), .rd_pq(rd_pq), .ntf_vec(ntf_vec));

    pq_source_gate #(.NUM_SRC(8), .PAGE_SHIFT(16), .OFFSET_QUIRK(1'b1),
        .LSI_MASK(LSI), .SEOI_MASK(SEOI), .TRIG_PAGE_MASK(TPG)) u1 (
        .clk(clk), .rst(rst), .trig_valid(1'b0), .trig_src(3'd0),
        .op_valid(q_op_valid), .op_write(1'b0), .op_addr(q_op_addr),
        .rd_valid(q_rd_valid), .rd_pq(q_rd_pq), .ntf_vec(q_ntf_vec));

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    function automatic void fire(int s);
        if (!m_pq[s][1]) begin
            if (LSI[s] || !m_pq[s][0]) begin
                m_pq[s][1] = 1'b1;
                exp_ntf[s] = 1'b1;
            end
        end else if (!LSI[s]) begin
            m_pq[s][0] = 1'b1;
        end
    endfunction

    // R11: the model applies the operation, then the trigger
    function automatic void model(logic t_en, int t_s, logic o_en, logic o_wr,
                                  int o_s, logic [3:0] nib);
        exp_ntf = '0;
        exp_rv  = o_en && !o_wr;
        exp_rd  = m_pq[o_s];
        if (o_en) begin
            if (!o_wr) begin
                if (nib[3:2] == 2'b11) m_pq[o_s] = {nib[1], LSI[o_s] ? 1'b0 : nib[0]};
            end else if (nib == 4'h0) begin
                if (SEOI[o_s]) begin
                    m_pq[o_s] = {m_pq[o_s][0], 1'b0};
                    if (m_pq[o_s][1]) exp_ntf[o_s] = 1'b1;
                end else if (!TPG[o_s]) begin
                    fire(o_s);
                end
            end
        end
        if (t_en) fire(t_s);
    endfunction

    task automatic step(input logic t_en, input int t_s, input logic o_en,
                        input logic o_wr, input int o_s, input logic [3:0] nib,
                        input string tag);
        trig_valid = t_en;
        trig_src   = t_s[2:0];
        op_valid   = o_en;
        op_write   = o_wr;
        op_addr    = {o_s[2:0], nib, 8'($urandom)};
        model(t_en, t_s, o_en, o_wr, o_s, nib);
        @(negedge clk);
        trig_valid = 1'b0;
        op_valid   = 1'b0;
        check({tag, " ntf R12"}, ntf_vec, exp_ntf);
        check({tag, " rd_valid R5"}, {7'd0, rd_valid}, {7'd0, exp_rv});
        if (exp_rv) check({tag, " rd_pq"}, {6'd0, rd_pq}, {6'd0, exp_rd});
    endtask

    task automatic qload(input logic [15:0] off, input logic [1:0] exp, input string tag);
        q_op_valid = 1'b1;
        q_op_addr  = {3'd1, off};
        @(negedge clk);
        q_op_valid = 1'b0;
        check(tag, {6'd0, q_rd_pq}, {6'd0, exp});
        check({tag, " valid"}, {7'd0, q_rd_valid}, 8'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired got running exp finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int s = 0; s < 8; s++) m_pq[s] = LSI[s] ? 2'b10 : 2'b01;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset outputs, then reset state via plain reads (R6)
        check("R1 ntf after reset", ntf_vec, 8'd0);
        check("R1 rd_valid after reset", {7'd0, rd_valid}, 8'd0);
        for (int s = 0; s < 8; s++) step(0, 0, 1, 0, s, 4'h8, "R1 R6 reset state read");

        // R5, R2: arm source 0, trigger sequence
        step(0, 0, 1, 0, 0, 4'hC, "R5 set 00");
        step(1, 0, 0, 0, 0, 4'h0, "R2 00 trig notifies");
        step(1, 0, 0, 0, 0, 4'h0, "R2 10 trig records");
        step(1, 0, 0, 0, 0, 4'h0, "R2 11 trig stays");
        step(0, 0, 1, 0, 0, 4'h9, "R2 read 11");
        // R7: store-EOI replays then clears
        step(0, 0, 1, 1, 0, 4'h0, "R7 seoi replay");
        step(0, 0, 1, 1, 0, 4'h0, "R7 seoi clear");
        step(0, 0, 1, 0, 0, 4'h8, "R7 read 00");
        // R3: off source drops triggers
        step(1, 1, 0, 0, 0, 4'h0, "R3 off trig");
        step(0, 0, 1, 0, 1, 4'h8, "R3 read 01");
        // R4: level-sensitive source
        step(0, 0, 1, 0, 6, 4'hC, "R4 set 00");
        step(1, 6, 0, 0, 0, 4'h0, "R4 trig notifies");
        step(1, 6, 0, 0, 0, 4'h0, "R4 trig ignored");
        step(0, 0, 1, 0, 6, 4'hF, "R4 write 11");
        step(0, 0, 1, 0, 6, 4'h8, "R4 q dropped");
        // R8: store acts as trigger
        step(0, 0, 1, 0, 3, 4'hC, "R8 set 00");
        step(0, 0, 1, 1, 3, 4'h0, "R8 store triggers");
        step(0, 0, 1, 0, 3, 4'h8, "R8 read 10");
        // R9: ignored stores
        step(0, 0, 1, 0, 4, 4'hC, "R9 set 00");
        step(0, 0, 1, 1, 4, 4'h0, "R9 store ignored");
        step(0, 0, 1, 1, 0, 4'h5, "R9 odd nibble store");
        step(0, 0, 1, 0, 4, 4'h8, "R9 read 00");
        // R11: op and trigger same source same cycle
        step(1, 2, 1, 0, 2, 4'hC, "R11 set then trig");
        step(0, 0, 1, 0, 2, 4'hA, "R11 read 10");
        // R10: quirk placement of the operation nibble
        qload(16'h0D00, 2'b01, "R10 quirk low nibble is plain read");
        qload(16'hE0F0, 2'b01, "R10 quirk set 10");
        qload(16'h0000, 2'b10, "R10 quirk read back");
        check("R10 quirk no ntf", q_ntf_vec, 8'd0);

        for (int k = 0; k < 4000; k++) begin
            logic [3:0] nb;
            case ($urandom % 7)
                0: nb = 4'h0; 1: nb = 4'hC; 2: nb = 4'hD; 3: nb = 4'hE;
                4: nb = 4'hF; 5: nb = 4'h8; default: nb = 4'h5;
            endcase
            step(1'($urandom), int'($urandom % 8), 1'($urandom), 1'($urandom),
                 int'($urandom % 8), nb, "R2 R10 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule